// File: doc/BRIEF.md
# Precise Exception Recognition Sequencer

This block sits at the completion point of a core that completes instructions in order. It gathers three kinds of exception evidence. The first is a fault from the fetch side that has no instruction attached to it. The second is a fault that dispatch or execute logic reports against a specific in-flight instruction tag. The third is a trace event that follows the completion of an instruction while tracing is on. From these it decides which exception the core takes, and in which cycle. It does not vector to a handler or save state. It reports the exception class, the instruction tag involved and whether that instruction completed.

A fetch fault stops dispatch at once and lets the older work drain. The fetch exception is recognised only when the pipeline is empty and in a recoverable state. An execution fault recorded against a tag is held until that instruction reaches the completion point, so every older instruction has already completed. It is then taken without completing the faulting instruction. Whenever an exception is taken, all other pending records are discarded. This makes the oldest exception always win.

Instruction tags are 4 bits wide and wrap. Age is measured as the distance, modulo 16, from the oldest uncompleted tag. Only tags less than `WINDOW` (default 8) away from that tag count as in flight.

Top module: `exc_precise_seq`

## Requirements
- R1: While reset is low, and after it is released, `halt_dispatch_o` and `take_o` are 0 and `take_class_o` is 000, and no exception record is pending.
- R2: `halt_dispatch_o` goes high combinationally in the cycle in which `fetch_fault_i` is high. It stays high until the cycle that follows the take pulse.
- R3: A pending fetch fault is taken only in a cycle with `pipe_empty_i` and `recoverable_i` both high and no completion presented. The result is class 001, with `take_tag_o` equal to the oldest uncompleted tag and `take_done_o` 0.
- R4: If an instruction completing while a fetch fault is pending raises its own exception, that exception is taken and the fetch fault is dropped. No later fetch take occurs and the halt is released.
- R5: An execution fault reported for an in-window tag is taken when that tag is presented on the completion port. The result is class 010, with that tag on `take_tag_o` and `take_done_o` 0.
- R6: When faults are pending on several tags, the oldest is taken first and every other pending record is discarded. A later completion of the discarded tags produces no take.
- R7: A completion presented while `trace_en_i` is 1 and no fault is recorded for that tag produces class 100, with that tag and `take_done_o` 1. With `trace_en_i` 0, a clean completion produces no take.
- R8: If a completing instruction has a fault report (recorded earlier, or arriving in the same cycle) and tracing is on, class 010 is taken and no trace take follows for it.
- R9: A fault report whose tag lies `WINDOW` or more ahead of the oldest uncompleted tag is ignored. Completing that tag later produces no take.
- R10: The take outputs are registered and appear in the cycle after the deciding edge. `take_o` lasts one cycle unless a new take is decided. `take_class_o` is one-hot when `take_o` is 1 and 000 otherwise. In the cycle after a take, `halt_dispatch_o` is high only if `take_o` or `fetch_fault_i` is high.
- R11: Tag distance is computed modulo 16. A fault on tag 0 reported while tag 15 is oldest is in flight and is taken when tag 0 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_fault_i | input | 1 | Fetch-side fault detected this cycle |
| xrep_valid_i | input | 1 | Dispatch/execute fault report valid |
| xrep_tag_i | input | 4 | Tag of the faulting instruction |
| cmp_valid_i | input | 1 | Oldest instruction reaches completion this cycle |
| cmp_tag_i | input | 4 | Tag of the instruction at completion |
| trace_en_i | input | 1 | Trace mode enabled |
| pipe_empty_i | input | 1 | No instruction in flight |
| recoverable_i | input | 1 | Machine is in a recoverable state |
| halt_dispatch_o | output | 1 | Stop dispatching new instructions |
| take_o | output | 1 | One-cycle exception-taken pulse |
| take_class_o | output | 3 | 001 fetch, 010 dispatch/execute, 100 trace, 000 none |
| take_tag_o | output | 4 | Tag saved with the taken exception |
| take_done_o | output | 1 | 1 if that instruction completed |

## Verification
The assertions assume that the completion port presents tags in program order and that each tag is the oldest uncompleted one. They also assume that `pipe_empty_i` is never high in a cycle that carries a completion. After any take, the first completion carries the tag of the instruction that did not complete, or the next tag after a trace take. The directed tasks keep a model of the oldest tag in the bench and complete strictly from it. They raise the empty and recoverable flags only in idle cycles, so the stimulus never leaves these limits.

// File: rtl/exc_seq_pkg.sv
// Package: shared exception class encoding for the precise exception sequencer.
// Assumes: classes are one-hot so that a downstream decoder needs one gate each.
package exc_seq_pkg;
    typedef enum logic [2:0] {
        EXC_NONE  = 3'b000,
        EXC_FETCH = 3'b001,
        EXC_DX    = 3'b010,
        EXC_TRACE = 3'b100
    } exc_class_e;
endpackage

// File: rtl/exc_age_calc.sv
// Module: modular distance of a tag from the oldest uncompleted tag.
// Assumes: WINDOW <= 2**TAG_W; tags outside the window are not in flight.
module exc_age_calc #(
    parameter int TAG_W  = 4,
    parameter int WINDOW = 8
) (
    input  logic [TAG_W-1:0] head_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [TAG_W-1:0] dist_o,
    output logic             in_win_o
);
    localparam logic [TAG_W:0] WIN_L = WINDOW[TAG_W:0];

    // Distance wraps naturally in TAG_W bits; window check on a widened copy.
    always_comb begin
        dist_o   = tag_i - head_i;
        in_win_o = ({1'b0, dist_o} < WIN_L);
    end
endmodule

// File: rtl/exc_pend_table.sv
// Module: one pending-fault bit per tag value.
// Assumes: flush has priority over set, set over clear.
module exc_pend_table #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             set_i,
    input  logic [TAG_W-1:0] set_tag_i,
    input  logic             clr_i,
    input  logic [TAG_W-1:0] clr_tag_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic             rd_o
);
    localparam int DEPTH = 1 << TAG_W;

    logic [DEPTH-1:0] pend_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Per-tag record: reset/flush clears, a report sets, a completion clears.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i)
                pend_q[g] <= 1'b0;
            else if (set_i && set_tag_i == TAG_W'(g))
                pend_q[g] <= 1'b1;
            else if (clr_i && clr_tag_i == TAG_W'(g))
                pend_q[g] <= 1'b0;
        end
    end

    // Read port for the tag now at completion.
    assign rd_o = pend_q[rd_tag_i];
endmodule

// File: rtl/exc_arbiter.sv
// Module: per-cycle exception decision in priority order.
// Assumes: a completion and an empty pipeline never coincide; the completion
// presented is the oldest instruction, so its fault beats any younger one.
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic       cmp_valid_i,
    input  logic       cmp_fault_i,
    input  logic       trace_en_i,
    input  logic       fetch_pend_i,
    input  logic       pipe_empty_i,
    input  logic       recoverable_i,
    output logic       take_o,
    output exc_class_e class_o,
    output logic       done_o,
    output logic       use_head_o,
    output logic       advance_o
);
    // Completion fault first, then trace on clean completion, then drained fetch.
    always_comb begin
        take_o     = 1'b0;
        class_o    = EXC_NONE;
        done_o     = 1'b0;
        use_head_o = 1'b0;
        advance_o  = cmp_valid_i && !cmp_fault_i;
        if (cmp_valid_i && cmp_fault_i) begin
            take_o  = 1'b1;
            class_o = EXC_DX;
        end else if (cmp_valid_i && trace_en_i) begin
            take_o  = 1'b1;
            class_o = EXC_TRACE;
            done_o  = 1'b1;
        end else if (!cmp_valid_i && fetch_pend_i && pipe_empty_i && recoverable_i) begin
            take_o     = 1'b1;
            class_o    = EXC_FETCH;
            use_head_o = 1'b1;
        end
    end
endmodule

// File: rtl/exc_precise_seq.sv
// Module: precise exception recognition sequencer (top).
// Collects fetch faults, per-tag execute faults and trace events, and emits a
// registered one-cycle take pulse with class, tag and completed flag.
// Assumes: in-order completion with cmp_tag_i equal to the oldest tag.
module exc_precise_seq
    import exc_seq_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int WINDOW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_fault_i,
    input  logic             xrep_valid_i,
    input  logic [TAG_W-1:0] xrep_tag_i,
    input  logic             cmp_valid_i,
    input  logic [TAG_W-1:0] cmp_tag_i,
    input  logic             trace_en_i,
    input  logic             pipe_empty_i,
    input  logic             recoverable_i,
    output logic             halt_dispatch_o,
    output logic             take_o,
    output logic [2:0]       take_class_o,
    output logic [TAG_W-1:0] take_tag_o,
    output logic             take_done_o
);
    logic [TAG_W-1:0] head_q;
    logic             fetch_pend_q;
    logic             take_q;
    exc_class_e       class_q;
    logic [TAG_W-1:0] tag_q;
    logic             done_q;

    logic [TAG_W-1:0] xrep_dist;
    logic             xrep_in_win;
    logic             rec_fault;
    logic             cmp_fault;
    logic             take_now;
    exc_class_e       class_now;
    logic             done_now;
    logic             use_head;
    logic             advance;

    exc_age_calc #(.TAG_W(TAG_W), .WINDOW(WINDOW)) u_age (
        .head_i   (head_q),
        .tag_i    (xrep_tag_i),
        .dist_o   (xrep_dist),
        .in_win_o (xrep_in_win)
    );

    exc_pend_table #(.TAG_W(TAG_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (take_now),
        .set_i     (xrep_valid_i && xrep_in_win),
        .set_tag_i (xrep_tag_i),
        .clr_i     (advance),
        .clr_tag_i (cmp_tag_i),
        .rd_tag_i  (cmp_tag_i),
        .rd_o      (rec_fault)
    );

    // A completing instruction is faulty if recorded or reported this cycle.
    assign cmp_fault = rec_fault || (xrep_valid_i && xrep_in_win && xrep_tag_i == cmp_tag_i);

    exc_arbiter u_arb (
        .cmp_valid_i   (cmp_valid_i),
        .cmp_fault_i   (cmp_fault),
        .trace_en_i    (trace_en_i),
        .fetch_pend_i  (fetch_pend_q),
        .pipe_empty_i  (pipe_empty_i),
        .recoverable_i (recoverable_i),
        .take_o        (take_now),
        .class_o       (class_now),
        .done_o        (done_now),
        .use_head_o    (use_head),
        .advance_o     (advance)
    );

    // Oldest uncompleted tag follows the completion stream.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_q <= '0;
        else if (advance)
            head_q <= cmp_tag_i + TAG_W'(1);
    end

    // Fetch fault record: set on detection, dropped by any take.
    always_ff @(posedge clk) begin
        if (!rst_n || take_now)
            fetch_pend_q <= 1'b0;
        else if (fetch_fault_i)
            fetch_pend_q <= 1'b1;
    end

    // Registered take outputs, a pulse per decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q  <= 1'b0;
            class_q <= EXC_NONE;
            tag_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            take_q  <= take_now;
            class_q <= class_now;
            tag_q   <= use_head ? head_q : cmp_tag_i;
            done_q  <= done_now;
        end
    end

    // Halt at once on a fetch fault, hold while pending and through the pulse.
    assign halt_dispatch_o = fetch_fault_i || fetch_pend_q || take_q;
    assign take_o          = take_q;
    assign take_class_o    = class_q;
    assign take_tag_o      = tag_q;
    assign take_done_o     = done_q;

    // Distance is computed for the window check; keep its full value observable.
    logic unused_dist;
    assign unused_dist = ^xrep_dist;
endmodule

// File: rtl/exc_precise_seq_chk.sv
// Module: port-level protocol checks for exc_precise_seq, bound below.
// Assumes: inputs obey the completion-order rules stated in the brief.
module exc_precise_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_fault_i,
    input logic       cmp_valid_i,
    input logic       trace_en_i,
    input logic       pipe_empty_i,
    input logic       recoverable_i,
    input logic       halt_dispatch_o,
    input logic       take_o,
    input logic [2:0] take_class_o,
    input logic       take_done_o
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!take_o && take_class_o == 3'b000)); // R1
    AST_IDLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n) !take_o |-> take_class_o == 3'b000); // R10
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) take_o |-> $onehot(take_class_o)); // R10
    AST_HALT_AT_FAULT: assert property (@(posedge clk) disable iff (!rst_n) fetch_fault_i |-> halt_dispatch_o); // R2
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) fetch_fault_i |=> halt_dispatch_o); // R2
    AST_FETCH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n) (take_o && take_class_o == 3'b001) |-> $past(pipe_empty_i && recoverable_i && !cmp_valid_i)); // R3
    AST_FETCH_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) (take_o && take_class_o == 3'b001) |-> !take_done_o); // R3
    AST_DX_AT_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n) (take_o && take_class_o == 3'b010) |-> ($past(cmp_valid_i) && !take_done_o)); // R5
    AST_TRACE_DONE: assert property (@(posedge clk) disable iff (!rst_n) (take_o && take_class_o == 3'b100) |-> (take_done_o && $past(trace_en_i && cmp_valid_i))); // R7
    AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) take_o |=> (halt_dispatch_o == (take_o || fetch_fault_i))); // R10
endmodule

bind exc_precise_seq exc_precise_seq_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_fault_i   (fetch_fault_i),
    .cmp_valid_i     (cmp_valid_i),
    .trace_en_i      (trace_en_i),
    .pipe_empty_i    (pipe_empty_i),
    .recoverable_i   (recoverable_i),
    .halt_dispatch_o (halt_dispatch_o),
    .take_o          (take_o),
    .take_class_o    (take_class_o),
    .take_done_o     (take_done_o)
);

// File: tb/exc_precise_seq_tb_top.sv
// Bench: directed scenarios, one task each, checking at the ports.
module exc_precise_seq_tb_top;
    localparam int TAG_W  = 4;
    localparam int WINDOW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fetch_fault_i = 1'b0;
    logic             xrep_valid_i = 1'b0;
    logic [TAG_W-1:0] xrep_tag_i = '0;
    logic             cmp_valid_i = 1'b0;
    logic [TAG_W-1:0] cmp_tag_i = '0;
    logic             trace_en_i = 1'b0;
    logic             pipe_empty_i = 1'b0;
    logic             recoverable_i = 1'b0;
    logic             halt_dispatch_o;
    logic             take_o;
    logic [2:0]       take_class_o;
    logic [TAG_W-1:0] take_tag_o;
    logic             take_done_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [TAG_W-1:0] h = '0;

    always #2.5 clk = ~clk;

    exc_precise_seq #(.TAG_W(TAG_W), .WINDOW(WINDOW)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        fetch_fault_i = 0; xrep_valid_i = 0; cmp_valid_i = 0;
        trace_en_i = 0; pipe_empty_i = 0; recoverable_i = 0;
    endtask

    // Present a completion of the oldest tag, step, and check for no take.
    task automatic complete_clean(input string req);
        cmp_valid_i = 1; cmp_tag_i = h;
        step();
        idle();
        chk(req, int'(take_o), 0);
        h = h + 1'b1;
    endtask

    task automatic expect_take(input string req, input int cls, input int tag, input int done);
        chk({req, " take"}, int'(take_o), 1);
        chk({req, " class"}, int'(take_class_o), cls);
        chk({req, " tag"}, int'(take_tag_o), tag);
        chk({req, " done"}, int'(take_done_o), done);
    endtask

    task automatic t_reset();
        chk("R1 halt", int'(halt_dispatch_o), 0);
        chk("R1 take", int'(take_o), 0);
        chk("R1 class", int'(take_class_o), 0);
        complete_clean("R1 no pending");
    endtask

    task automatic t_trace();
        trace_en_i = 1; cmp_valid_i = 1; cmp_tag_i = h;
        step();
        idle();
        expect_take("R7", 3'b100, int'(h), 1);
        h = h + 1'b1;
        step();
        chk("R10 pulse ends", int'(take_o), 0);
        complete_clean("R7 trace off");
    endtask

    task automatic t_fetch();
        fetch_fault_i = 1;
        #1;
        chk("R2 halt same cycle", int'(halt_dispatch_o), 1);
        step();
        idle();
        chk("R2 halt held", int'(halt_dispatch_o), 1);
        pipe_empty_i = 1;
        step();
        chk("R3 not recoverable", int'(take_o), 0);
        chk("R2 still halted", int'(halt_dispatch_o), 1);
        recoverable_i = 1;
        step();
        idle();
        expect_take("R3", 3'b001, int'(h), 0);
        chk("R10 halt in pulse", int'(halt_dispatch_o), 1);
        step();
        chk("R10 halt released", int'(halt_dispatch_o), 0);
        chk("R10 single pulse", int'(take_o), 0);
    endtask

    task automatic t_fetch_drain_fault();
        fetch_fault_i = 1;
        step();
        idle();
        complete_clean("R4 clean drain");
        xrep_valid_i = 1; xrep_tag_i = h; cmp_valid_i = 1; cmp_tag_i = h;
        step();
        idle();
        expect_take("R4", 3'b010, int'(h), 0);
        step();
        chk("R4 halt released", int'(halt_dispatch_o), 0);
        pipe_empty_i = 1; recoverable_i = 1;
        step();
        idle();
        chk("R4 fetch dropped", int'(take_o), 0);
        step();
    endtask

    task automatic t_older();
        xrep_valid_i = 1; xrep_tag_i = h + 2'd2;
        step();
        xrep_tag_i = h + 1'b1;
        step();
        idle();
        complete_clean("R6 oldest clean");
        cmp_valid_i = 1; cmp_tag_i = h;
        step();
        idle();
        expect_take("R6", 3'b010, int'(h), 0);
        step();
        complete_clean("R5 refetched clean");
        complete_clean("R6 younger discarded");
    endtask

    task automatic t_fault_vs_trace();
        trace_en_i = 1; xrep_valid_i = 1; xrep_tag_i = h;
        cmp_valid_i = 1; cmp_tag_i = h;
        step();
        idle();
        expect_take("R8", 3'b010, int'(h), 0);
        step();
        chk("R8 no trace after", int'(take_o), 0);
    endtask

    task automatic t_window();
        xrep_valid_i = 1; xrep_tag_i = h + 4'(WINDOW);
        step();
        idle();
        for (int i = 0; i <= WINDOW; i++) complete_clean("R9 out of window");
    endtask

    task automatic t_wrap();
        while (h != 4'd15) complete_clean("R11 advance");
        xrep_valid_i = 1; xrep_tag_i = 4'd0;
        step();
        idle();
        complete_clean("R11 tag 15");
        cmp_valid_i = 1; cmp_tag_i = h;
        step();
        idle();
        expect_take("R11", 3'b010, 0, 0);
        step();
    endtask

    initial begin
        repeat (3) step();
        chk("R1 under reset", int'(take_o), 0);
        rst_n = 1;
        step();
        t_reset();
        t_trace();
        t_fetch();
        t_fetch_drain_fault();
        t_older();
        t_fault_vs_trace();
        t_window();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule